// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block turns the byte writes a console CPU makes into its cartridge space from 0x8000 up into bank numbers for the external memories. It holds one bank-select register, four program bank registers of 8 KB each, eight pattern bank registers of 1 KB each, and a nametable mirroring register. The four CPU windows that cover 0x8000–0xFFFF each receive a program bank number. Each of the eight 1 KB pattern windows receives a bank number and a flag that sends the fetch to on-cartridge pattern RAM or to pattern ROM.

Firmware first writes the bank-select register. The low nibble of that register names the target of the next data write. Bit 6 swaps which program registers drive CPU windows 0 and 2. Bit 7 swaps the two 4 KB halves of pattern space. Every output is decoded combinationally from the registers. A write therefore changes the mapping on the first clock after the edge that captures it.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the pattern registers hold 0..7 in slot order. The program registers hold 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Bank-select and mirroring are 0.
- R2: A write is decoded only when `cpu_we` is high and address bit 15 is 1. The decode uses only bits 14, 13 and 0. {14,13,0} = 000 is bank-select, 001 is data, and 010 is mirroring. Any other combination, any other address bit, or a write with bit 15 clear leaves every output unchanged.
- R3: A data write goes to the target named by bank-select[3:0]. 0 selects pattern slot 0, 1 selects slot 2, and 2, 3, 4, 5 select slots 4, 5, 6, 7. 6, 7, 8, 9 select program slots 0, 1, 2, 3. 0xA selects pattern slot 1 and 0xB selects slot 3.
- R4: A data write while bank-select[3:0] is 0xC–0xF changes nothing.
- R5: When bank-select bit 6 is 1, CPU window 0 shows program register 2 and window 2 shows register 0. Windows 1 and 3 always show registers 1 and 3.
- R6: When bank-select bit 7 is 1, pattern window w shows pattern register w XOR 4. Its RAM flag follows that same register.
- R7: A pattern window's RAM flag is 1 when its bank number is 7 or less. It is 0 when the bank number is 8 or more.
- R8: The mirroring output equals data bits [1:0] of the last mirroring write: 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R9: Outputs change only on the clock after an accepted write, and they show the new mapping from that cycle on.
- R10: Program bank outputs are the written value modulo PRG_BANKS, which is a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Write strobe, one cycle per CPU write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| prg_bank | output | 4*PRG_W | Program bank for CPU window w at bits [w*PRG_W +: PRG_W] |
| chr_bank | output | 8*CHR_W | Pattern bank for 1 KB window w at bits [w*CHR_W +: CHR_W] |
| chr_ram_sel | output | 8 | Bit w set: window w fetches from pattern RAM |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The bound checker watches four things on every cycle. Outputs hold when no write is accepted, and this includes writes below 0x8000 and data writes to the unused targets 0xC–0xF. The mirroring output follows a mirroring write. A bank-select write that flips bit 6 swaps exactly CPU windows 0 and 2, and one that flips bit 7 swaps the pattern halves. Several behaviours only the bench scenarios can show. These are the reset values, the routing of each target index to its register, masking to the program size, the RAM/ROM boundary at 7 and 8, and the address aliasing. The bench compares all of them every clock against its behavioural model.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int PRG_SLOTS = 4;
    localparam int CHR_SLOTS = 8;

    // decode key formed from {addr[14], addr[13], addr[0]}
    typedef enum logic [2:0] {
        KEY_SELECT = 3'b000,
        KEY_DATA   = 3'b001,
        KEY_MIRROR = 3'b010
    } wkey_e;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

endpackage

// File: rtl/cart_map_wdec.sv
module cart_map_wdec
    import cart_map_pkg::*;
(
    input  logic                 we,
    input  logic [15:0]          addr,
    input  logic [3:0]           target,
    output logic                 ld_sel,
    output logic                 ld_mir,
    output logic [CHR_SLOTS-1:0] ld_chr,
    output logic [PRG_SLOTS-1:0] ld_prg
);

    logic [2:0] key;
    assign key = {addr[14:13], addr[0]};

    always_comb begin
        ld_sel = 1'b0;
        ld_mir = 1'b0;
        ld_chr = '0;
        ld_prg = '0;
        if (we && addr[15]) begin
            case (key)
                KEY_SELECT: ld_sel = 1'b1;
                KEY_MIRROR: ld_mir = 1'b1;
                KEY_DATA: begin
                    case (target)
                        4'h0: ld_chr[0] = 1'b1;
                        4'h1: ld_chr[2] = 1'b1;
                        4'h2: ld_chr[4] = 1'b1;
                        4'h3: ld_chr[5] = 1'b1;
                        4'h4: ld_chr[6] = 1'b1;
                        4'h5: ld_chr[7] = 1'b1;
                        4'h6: ld_prg[0] = 1'b1;
                        4'h7: ld_prg[1] = 1'b1;
                        4'h8: ld_prg[2] = 1'b1;
                        4'h9: ld_prg[3] = 1'b1;
                        4'hA: ld_chr[1] = 1'b1;
                        4'hB: ld_chr[3] = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cart_map_regs.sv
module cart_map_regs
    import cart_map_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int PRG_W     = 5,
    parameter int CHR_W     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [7:0]                          wdata,
    input  logic                                ld_sel,
    input  logic                                ld_mir,
    input  logic [CHR_SLOTS-1:0]                ld_chr,
    input  logic [PRG_SLOTS-1:0]                ld_prg,
    output logic [7:0]                          sel_q,
    output logic [1:0]                          mir_q,
    output logic [PRG_SLOTS-1:0][PRG_W-1:0]     prg_q,
    output logic [CHR_SLOTS-1:0][CHR_W-1:0]     chr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            mir_q <= MIR_VERT;
        end else begin
            if (ld_sel) sel_q <= wdata;
            if (ld_mir) mir_q <= wdata[1:0];
        end
    end

    for (genvar p = 0; p < PRG_SLOTS; p++) begin : g_prg
        localparam int RST_VAL = (p < 2) ? p : (PRG_BANKS - PRG_SLOTS + p);
        always_ff @(posedge clk) begin
            if (!rst_n)         prg_q[p] <= PRG_W'(RST_VAL);
            else if (ld_prg[p]) prg_q[p] <= wdata[PRG_W-1:0];
        end
    end

    for (genvar c = 0; c < CHR_SLOTS; c++) begin : g_chr
        always_ff @(posedge clk) begin
            if (!rst_n)         chr_q[c] <= CHR_W'(c);
            else if (ld_chr[c]) chr_q[c] <= CHR_W'(wdata);
        end
    end

endmodule

// File: rtl/cart_map_xlate.sv
module cart_map_xlate
    import cart_map_pkg::*;
#(
    parameter int PRG_W    = 5,
    parameter int CHR_W    = 8,
    parameter int RAM_LAST = 7
) (
    input  logic [7:0]                          sel_q,
    input  logic [PRG_SLOTS-1:0][PRG_W-1:0]     prg_q,
    input  logic [CHR_SLOTS-1:0][CHR_W-1:0]     chr_q,
    output logic [PRG_SLOTS*PRG_W-1:0]          prg_win,
    output logic [CHR_SLOTS*CHR_W-1:0]          chr_win,
    output logic [CHR_SLOTS-1:0]                chr_ram
);

    logic prg_swap;
    logic chr_swap;
    assign prg_swap = sel_q[6];
    assign chr_swap = sel_q[7];

    for (genvar w = 0; w < PRG_SLOTS; w++) begin : g_pw
        if ((w % 2) == 0) begin : g_swappable
            assign prg_win[w*PRG_W +: PRG_W] = prg_swap ? prg_q[w ^ 2] : prg_q[w];
        end else begin : g_fixed
            assign prg_win[w*PRG_W +: PRG_W] = prg_q[w];
        end
    end

    for (genvar w = 0; w < CHR_SLOTS; w++) begin : g_cw
        logic [CHR_W-1:0] bank;
        assign bank = chr_swap ? chr_q[w ^ 4] : chr_q[w];
        assign chr_win[w*CHR_W +: CHR_W] = bank;
        assign chr_ram[w] = (bank <= CHR_W'(RAM_LAST));
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter int PRG_BANKS  = 32,
    parameter int CHR_W      = 8,
    localparam int PRG_W     = $clog2(PRG_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_we,
    input  logic [15:0]                cpu_addr,
    input  logic [7:0]                 cpu_wdata,
    output logic [4*PRG_W-1:0]         prg_bank,
    output logic [8*CHR_W-1:0]         chr_bank,
    output logic [7:0]                 chr_ram_sel,
    output logic [1:0]                 mirror_mode
);

    logic                            ld_sel;
    logic                            ld_mir;
    logic [CHR_SLOTS-1:0]            ld_chr;
    logic [PRG_SLOTS-1:0]            ld_prg;
    logic [7:0]                      sel_q;
    logic [1:0]                      mir_q;
    logic [PRG_SLOTS-1:0][PRG_W-1:0] prg_q;
    logic [CHR_SLOTS-1:0][CHR_W-1:0] chr_q;

    cart_map_wdec u_wdec (
        .we     (cpu_we),
        .addr   (cpu_addr),
        .target (sel_q[3:0]),
        .ld_sel (ld_sel),
        .ld_mir (ld_mir),
        .ld_chr (ld_chr),
        .ld_prg (ld_prg)
    );

    cart_map_regs #(
        .PRG_BANKS (PRG_BANKS),
        .PRG_W     (PRG_W),
        .CHR_W     (CHR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (cpu_wdata),
        .ld_sel (ld_sel),
        .ld_mir (ld_mir),
        .ld_chr (ld_chr),
        .ld_prg (ld_prg),
        .sel_q  (sel_q),
        .mir_q  (mir_q),
        .prg_q  (prg_q),
        .chr_q  (chr_q)
    );

    cart_map_xlate #(
        .PRG_W    (PRG_W),
        .CHR_W    (CHR_W),
        .RAM_LAST (7)
    ) u_xlate (
        .sel_q   (sel_q),
        .prg_q   (prg_q),
        .chr_q   (chr_q),
        .prg_win (prg_bank),
        .chr_win (chr_bank),
        .chr_ram (chr_ram_sel)
    );

    assign mirror_mode = mir_q;

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
    parameter int PRG_W = 5,
    parameter int CHR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_we,
    input logic [15:0]        cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic [4*PRG_W-1:0] prg_bank,
    input logic [8*CHR_W-1:0] chr_bank,
    input logic [7:0]         chr_ram_sel,
    input logic [1:0]         mirror_mode,
    input logic [7:0]         sel_q
);

    logic sel_wr;
    logic mir_wr;
    logic dat_wr;
    assign sel_wr = cpu_we && (cpu_addr[15:13] == 3'b100) && !cpu_addr[0];
    assign dat_wr = cpu_we && (cpu_addr[15:13] == 3'b100) &&  cpu_addr[0];
    assign mir_wr = cpu_we && (cpu_addr[15:13] == 3'b101) && !cpu_addr[0];

    // R9: no accepted write, no change
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_we) |-> ($stable(prg_bank) && $stable(chr_bank)
                            && $stable(chr_ram_sel) && $stable(mirror_mode)));

    // R2: writes below the cartridge register space are ignored
    a_r2_low_space: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_we && !cpu_addr[15]) |-> ($stable(prg_bank) && $stable(chr_bank)
                                           && $stable(mirror_mode)));

    // R4: unused target indices drop the data
    a_r4_unused_target: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dat_wr && (sel_q[3:2] == 2'b11)) |-> ($stable(prg_bank) && $stable(chr_bank)
                                                   && $stable(chr_ram_sel)));

    // R8: mirroring follows its write
    a_r8_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mir_wr) |-> (mirror_mode == $past(cpu_wdata[1:0])));

    // R5: toggling the program swap exchanges windows 0 and 2 only
    a_r5_prg_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_wr) && ($past(sel_q[6]) != sel_q[6])) |->
        ((prg_bank[0 +: PRG_W] == $past(prg_bank[2*PRG_W +: PRG_W]))
         && (prg_bank[2*PRG_W +: PRG_W] == $past(prg_bank[0 +: PRG_W]))
         && (prg_bank[PRG_W +: PRG_W] == $past(prg_bank[PRG_W +: PRG_W]))
         && (prg_bank[3*PRG_W +: PRG_W] == $past(prg_bank[3*PRG_W +: PRG_W]))));

    // R6: toggling the pattern swap exchanges the 4 KB halves
    a_r6_chr_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_wr) && ($past(sel_q[7]) != sel_q[7])) |->
        ((chr_bank == {$past(chr_bank[4*CHR_W-1:0]), $past(chr_bank[8*CHR_W-1:4*CHR_W])})
         && (chr_ram_sel == {$past(chr_ram_sel[3:0]), $past(chr_ram_sel[7:4])})));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
    .PRG_W (PRG_W),
    .CHR_W (CHR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .prg_bank    (prg_bank),
    .chr_bank    (chr_bank),
    .chr_ram_sel (chr_ram_sel),
    .mirror_mode (mirror_mode),
    .sel_q       (sel_q)
);

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;

    localparam int PRG_BANKS = 32;
    localparam int PRG_W     = 5;
    localparam int CHR_W     = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_we = 1'b0;
    logic [15:0]        cpu_addr = '0;
    logic [7:0]         cpu_wdata = '0;
    logic [4*PRG_W-1:0] prg_bank;
    logic [8*CHR_W-1:0] chr_bank;
    logic [7:0]         chr_ram_sel;
    logic [1:0]         mirror_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_sel, m_mir;
    int m_prg[4];
    int m_chr[8];

    always #4 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_W(CHR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .prg_bank(prg_bank), .chr_bank(chr_bank),
        .chr_ram_sel(chr_ram_sel), .mirror_mode(mirror_mode)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_sel = 0; m_mir = 0;
        for (int i = 0; i < 8; i++) m_chr[i] = i;
        m_prg[0] = 0; m_prg[1] = 1; m_prg[2] = PRG_BANKS - 2; m_prg[3] = PRG_BANKS - 1;
    endfunction

    function automatic void model_apply(logic [15:0] a, logic [7:0] d);
        int t;
        if (!a[15]) return;
        case ({a[14:13], a[0]})
            3'b000: m_sel = d;
            3'b010: m_mir = d & 3;
            3'b001: begin
                t = m_sel & 15;
                if (t == 0)       m_chr[0] = d;
                else if (t == 1)  m_chr[2] = d;
                else if (t <= 5)  m_chr[(t & 7) + 2] = d;
                else if (t <= 9)  m_prg[t - 6] = d % PRG_BANKS;
                else if (t == 10) m_chr[1] = d;
                else if (t == 11) m_chr[3] = d;
            end
            default: ;
        endcase
    endfunction

    function automatic int exp_prg(int w);
        int idx = w;
        if (((m_sel >> 6) & 1) == 1 && (w == 0 || w == 2)) idx = w ^ 2;
        return m_prg[idx];
    endfunction

    function automatic int exp_chr(int w);
        return m_chr[((m_sel >> 7) & 1) == 1 ? (w ^ 4) : w];
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int w = 0; w < 4; w++)
                chk(cur_req, $sformatf("prg window %0d", w), int'(prg_bank[w*PRG_W +: PRG_W]), exp_prg(w));
            for (int w = 0; w < 8; w++) begin
                chk(cur_req, $sformatf("chr window %0d", w), int'(chr_bank[w*CHR_W +: CHR_W]), exp_chr(w));
                chk(cur_req, $sformatf("ram flag %0d", w), int'(chr_ram_sel[w]), (exp_chr(w) <= 7) ? 1 : 0);
            end
            chk(cur_req, "mirror", int'(mirror_mode), m_mir);
        end
    end

    task automatic bus(bit we, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        #1;
        if (we) model_apply(a, d);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic set_target(logic [7:0] sel, logic [7:0] d);
        bus(1, 16'h8000, sel);
        bus(1, 16'h8001, d);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        cur_req = "R1";
        chk("R1", "prg window 2", int'(prg_bank[2*PRG_W +: PRG_W]), 30);
        chk("R1", "prg window 3", int'(prg_bank[3*PRG_W +: PRG_W]), 31);
        chk("R1", "chr window 5", int'(chr_bank[5*CHR_W +: CHR_W]), 5);
        chk("R1", "ram flags", int'(chr_ram_sel), 8'hFF);

        // R3 every valid target
        cur_req = "R3";
        for (int t = 0; t < 12; t++) set_target(8'(t), 8'(8'h40 + t));
        chk("R3", "slot for idx1 -> window2", int'(chr_bank[2*CHR_W +: CHR_W]), 8'h41);
        chk("R3", "slot for idx2 -> window4", int'(chr_bank[4*CHR_W +: CHR_W]), 8'h42);
        chk("R3", "slot for idxA -> window1", int'(chr_bank[1*CHR_W +: CHR_W]), 8'h4A);
        chk("R3", "idx9 -> prg window3", int'(prg_bank[3*PRG_W +: PRG_W]), 8'h49 % 32);
        chk("R3", "ram flag window0", int'(chr_ram_sel[0]), 0);

        // R4 unused targets
        cur_req = "R4";
        for (int t = 12; t < 16; t++) set_target(8'(t), 8'h03);
        chk("R4", "chr window 0 kept", int'(chr_bank[0 +: CHR_W]), 8'h40);

        // R10 masking to program size
        cur_req = "R10";
        set_target(8'h06, 8'hFF);
        chk("R10", "prg window 0 masked", int'(prg_bank[0 +: PRG_W]), 31);

        // R5 program swap
        cur_req = "R5";
        set_target(8'h08, 8'h0C);
        bus(1, 16'h8000, 8'h40);
        chk("R5", "window0 shows reg2", int'(prg_bank[0 +: PRG_W]), 12);
        chk("R5", "window2 shows reg0", int'(prg_bank[2*PRG_W +: PRG_W]), 31);
        bus(1, 16'h8000, 8'h00);

        // R7 boundary 7/8
        cur_req = "R7";
        set_target(8'h00, 8'h07);
        set_target(8'h03, 8'h08);
        chk("R7", "bank 7 is RAM", int'(chr_ram_sel[0]), 1);
        chk("R7", "bank 8 is ROM", int'(chr_ram_sel[5]), 0);

        // R6 pattern half swap
        cur_req = "R6";
        bus(1, 16'h8000, 8'h80);
        chk("R6", "window4 shows reg0", int'(chr_bank[4*CHR_W +: CHR_W]), 7);
        chk("R6", "ram flag window4", int'(chr_ram_sel[4]), 1);
        chk("R6", "window1 shows reg5", int'(chr_bank[1*CHR_W +: CHR_W]), 8);

        // R8 mirroring
        cur_req = "R8";
        bus(1, 16'hA000, 8'hFE);
        chk("R8", "mirror single lower", int'(mirror_mode), 2);
        bus(1, 16'hBFFE, 8'h07);
        chk("R8", "mirror single upper via alias", int'(mirror_mode), 3);

        // R2 decode: ignored keys, low space, strobe low, aliases
        cur_req = "R2";
        bus(1, 16'hA001, 8'h00);
        bus(1, 16'hC000, 8'h01);
        bus(1, 16'hE001, 8'h02);
        bus(1, 16'h2000, 8'h01);
        bus(0, 16'hA000, 8'h00);
        chk("R2", "mirror unchanged", int'(mirror_mode), 3);
        bus(1, 16'h9FFE, 8'h87);
        bus(1, 16'h9F03, 8'h15);
        chk("R2", "alias data write prg window1", int'(prg_bank[1*PRG_W +: PRG_W]), 8'h15 % 32);

        // R9 mixed traffic, model compared every cycle
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            a[15] = ($urandom % 4) != 0;
            bus(($urandom % 8) != 0, a, 8'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule